// File: doc/BRIEF.md
# Three-Mode Barrel Shifter

This is a purely combinational shifter. It takes a W-bit operand, an unsigned shift amount of configurable width and a two-bit mode. It returns the operand shifted left with zero fill, shifted right with zero fill, or shifted right with copies of the sign bit. There is no clock and no state, so the result follows the inputs within the same cycle.

The shifter builds every legal shifted value in advance. A binary selection tree, steered by the individual bits of the shift amount, picks one of them. A separate unsigned "amount below limit" comparison replaces the tree's output with the fill pattern when the amount is too large. The amount port may be wider than the bits needed to index W positions. Its upper bits then feed only the bounds comparison.

Top module: `mux_shift`

## Requirements
- R1: With mode 2'b00 and amount k < W, the output is operand bits W-1-k..0 placed above k zero bits.
- R2: With mode 2'b01 and amount k < W, the output is k zero bits placed above operand bits W-1..k.
- R3: With mode 2'b00, 2'b01 or 2'b11 and an amount of W or more, including the largest value the amount port can carry, the output is all zeros.
- R4: With mode 2'b10 and amount k < W-1, the output is k+1 copies of operand bit W-1 placed above operand bits W-2..k.
- R5: With mode 2'b10 and an amount of W-1 or more, every output bit equals operand bit W-1.
- R6: Mode 2'b11 gives the same output as mode 2'b01 for every operand and amount.
- R7: An amount of zero returns the operand unchanged in every mode.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| din | input | W | Operand to shift |
| amt | input | AW | Unsigned shift distance |
| mode | input | 2 | 00 left, 01 right logical, 10 right arithmetic, 11 right logical |
| dout | output | W | Shifted result |

## Verification
The checker compares the output with the language's shift operators. It assumes all inputs carry known 0/1 values, and it skips any evaluation in which an input is unknown. The bench therefore drives every input from the first time step, holding zero while its reset is active. After each change it waits a short settle time before sampling. The amount is swept through every value its port can hold, so the bench reaches the out-of-range region and the all-ones amount as well as 0, W-2, W-1 and W.

// File: rtl/mux_shift.sv
module mux_shift #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input  logic [W-1:0]  din,
  input  logic [AW-1:0] amt,
  input  logic [1:0]    mode,
  output logic [W-1:0]  dout
);
  localparam int SB = (W > 1) ? $clog2(W) : 1;
  localparam int P  = 1 << SB;
  localparam int EW = (AW > SB + 1) ? AW : SB + 1;

  function automatic int depth_of(input int idx);
    int d = 0;
    int n = idx + 1;
    while (n > 1) begin
      n = n >> 1;
      d++;
    end
    return d;
  endfunction

  logic [EW-1:0] amt_x;
  logic          sgn, is_ari, in_range;
  logic [W-1:0]  fill;
  logic [W-1:0]  node [2*P-1];

  assign amt_x    = EW'(amt);
  assign sgn      = din[W-1];
  assign is_ari   = (mode == 2'b10);
  assign fill     = is_ari ? {W{sgn}} : '0;
  assign in_range = amt_x < (is_ari ? EW'(W - 1) : EW'(W));

  for (genvar j = 0; j < P; j++) begin : g_leaf
    if (j == 0) begin : g_zero
      assign node[P-1] = din;
    end else if (j < W - 1) begin : g_all
      logic [W-1:0] lft, rlg, rar;
      assign lft = {din[W-1-j:0], {j{1'b0}}};
      assign rlg = {{j{1'b0}}, din[W-1:j]};
      assign rar = {{(j+1){sgn}}, din[W-2:j]};
      assign node[P-1+j] = (mode == 2'b00) ? lft : (is_ari ? rar : rlg);
    end else if (j == W - 1) begin : g_top
      logic [W-1:0] lft, rlg;
      assign lft = {din[0], {j{1'b0}}};
      assign rlg = {{j{1'b0}}, din[W-1]};
      assign node[P-1+j] = (mode == 2'b00) ? lft : (is_ari ? fill : rlg);
    end else begin : g_pad
      assign node[P-1+j] = fill;
    end
  end

  for (genvar i = 0; i < P - 1; i++) begin : g_tree
    localparam int D = depth_of(i);
    assign node[i] = amt_x[SB-1-D] ? node[2*i+2] : node[2*i+1];
  end

  assign dout = in_range ? node[0] : fill;
endmodule

// File: rtl/mux_shift_chk.sv
module mux_shift_chk #(
  parameter int W  = 16,
  parameter int AW = 6
) (
  input logic [W-1:0]  din,
  input logic [AW-1:0] amt,
  input logic [1:0]    mode,
  input logic [W-1:0]  dout
);
  logic signed [W-1:0] sdin;
  assign sdin = din;

  always_comb begin
    if (!$isunknown({din, amt, mode})) begin
      if (mode == 2'b00 && amt < AW'(W))
        p_left_r1: assert (dout == (din << amt)) else $error("R1 left shift mismatch");
      if (mode == 2'b01 && amt < AW'(W))
        p_rlog_r2: assert (dout == (din >> amt)) else $error("R2 right shift mismatch");
      if (mode != 2'b10 && !(amt < AW'(W)))
        p_zero_oob_r3: assert (dout == '0) else $error("R3 out of range not zero");
      if (mode == 2'b10 && amt < AW'(W - 1))
        p_rari_r4: assert (dout == W'(sdin >>> amt)) else $error("R4 arithmetic mismatch");
      if (mode == 2'b10 && !(amt < AW'(W - 1)))
        p_sign_sat_r5: assert (dout == {W{din[W-1]}}) else $error("R5 sign fill mismatch");
      if (mode == 2'b11)
        p_mode3_r6: assert (dout == (din >> amt)) else $error("R6 mode 3 mismatch");
      if (amt == '0)
        p_ident_r7: assert (dout == din) else $error("R7 zero amount changed data");
    end
  end
endmodule

bind mux_shift mux_shift_chk #(.W(W), .AW(AW)) u_chk (
  .din(din), .amt(amt), .mode(mode), .dout(dout)
);

// File: tb/test_mux_shift.sv
module test_mux_shift;
  localparam int W  = 16;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0]  din  = '0;
  logic [AW-1:0] amt  = '0;
  logic [1:0]    mode = 2'b00;
  logic [W-1:0]  dout;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  mux_shift #(.W(W), .AW(AW)) i_mux_shift (
    .din(din), .amt(amt), .mode(mode), .dout(dout)
  );

  task automatic check(input string req, input logic [W-1:0] exp);
    checks++;
    if (dout !== exp) begin
      errors++;
      $display("FAIL %s din=%h amt=%0d mode=%b actual=%h expected=%h",
               req, din, amt, mode, dout, exp);
    end
  endtask

  function automatic logic [W-1:0] model(input logic [W-1:0] d,
                                         input int a, input logic [1:0] m);
    logic signed [W-1:0] s = d;
    case (m)
      2'b00:   return (a >= W) ? '0 : d << a;
      2'b10:   return (a >= W - 1) ? {W{d[W-1]}} : W'(s >>> a);
      default: return (a >= W) ? '0 : d >> a;
    endcase
  endfunction

  function automatic string tag(input int a, input logic [1:0] m);
    if (a == 0) return "R7";
    if (m == 2'b00) return (a < W) ? "R1" : "R3";
    if (m == 2'b10) return (a < W - 1) ? "R4" : "R5";
    if (m == 2'b11) return "R6";
    return (a < W) ? "R2" : "R3";
  endfunction

  task automatic apply(input logic [W-1:0] d, input int a, input logic [1:0] m);
    @(negedge clk);
    din = d; amt = AW'(a); mode = m;
    #1;
    check(tag(a, m), model(d, a, m));
  endtask

  task automatic t_reset;
    @(negedge clk);
    #1;
    check("R7", '0);
  endtask

  task automatic t_sweep(input logic [1:0] m);
    logic [W-1:0] pats [5] = '{16'hA5C3, 16'h7FFE, 16'hFFFF, 16'h8000, 16'h1234};
    for (int p = 0; p < 5; p++)
      for (int a = 0; a < (1 << AW); a++)
        apply(pats[p], a, m);
  endtask

  task automatic t_corners;
    int amts [5] = '{0, W - 2, W - 1, W, (1 << AW) - 1};
    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 5; k++) begin
        apply(16'h8001, amts[k], 2'(m));
        apply(16'h4002, amts[k], 2'(m));
      end
  endtask

  task automatic t_mode3_vs_1;
    logic [W-1:0] r1;
    for (int a = 0; a < (1 << AW); a += 3) begin
      apply(16'hC3A9, a, 2'b01);
      r1 = dout;
      @(negedge clk);
      mode = 2'b11;
      #1;
      check("R6", r1);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    rst = 1'b0;
    t_sweep(2'b00);
    t_sweep(2'b01);
    t_sweep(2'b10);
    t_sweep(2'b11);
    t_corners();
    t_mode3_vs_1();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule